// File: doc/BRIEF.md
# Write-Once Thermal Shutdown Monitor

This block watches a set of signed 8-bit temperature readings, three from external sensing points and one from an on-die point. It drives a level shutdown output that a board uses to cut power when a part overheats. Each channel has a critical limit that software may set exactly once after power-on reset. That single write fixes the value and also arms the channel, so a later bad write cannot weaken the protection. Until a channel's limit has been written, that channel never causes a shutdown.

Two external channels can also tie their ordinary high limits to the shutdown output, under the control of configuration bits. Every channel reports its critical and high-limit hits in sticky status registers, and software clears a bit by writing a 1 to it. An alert output summarises the status registers through a per-bit mask register and a global mask bit. Host access is a flat 8-bit address and data port: reads are combinational and writes take effect on the clock edge. The high-limit values themselves arrive as input ports.

Top module: `tsm_top`

## Requirements
- R1: After reset, the four critical limits read 64h, all other registers read 00h, and the shutdown and alert outputs are low.
- R2: Read map: critical limits at 19h, 1Ah and 1Bh (external channels 0, 1, 2) and at 1Dh (internal channel 3); configuration at 20h; critical status at 22h; high status at 23h; interrupt status at 24h; alert mask at 25h. Configuration keeps only bits 7, 3 and 2, and the other bits read 0. Any other address reads 00h.
- R3: The first write to a critical-limit register stores the data. Every later write to that register is ignored until reset.
- R4: A channel whose critical limit has not been written never asserts shutdown and never sets its critical status bit.
- R5: For an armed channel, a temperature strictly greater than its limit sets the shutdown output, the channel's bit in critical status (bit i for channel i) and interrupt status bit 0, all on the clock edge after the sample. Equality is not a hit.
- R6: Shutdown is a level, not a latch. It drops on the edge after no armed critical hit and no linked high hit remain.
- R7: Configuration bit 2 links channel 1's high limit to shutdown, and bit 3 links channel 2's. A linked channel whose temperature is at or above its high limit asserts shutdown, and the shutdown releases once the temperature falls below that limit. The high limits of the other channels never drive shutdown.
- R8: Any channel at or above its high limit sets its bit in high status (bit i) and interrupt status bit 1, whether or not the channel is linked.
- R9: Status bits are sticky. Writing a 1 clears a bit, and a hit in the same cycle wins over the clear.
- R10: Alert is high when configuration bit 7 is 0 and some critical status bit i has mask bit i clear, or some high status bit i has mask bit 4+i clear. When configuration bit 7 is 1, alert stays low.
- R11: All comparisons are two's-complement signed (for example, 05h is above F6h).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| regAddr | input | 8 | Register address for read and write |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| tempIn | input | 32 | Channel temperatures, channel i in bits 8i+7:8i |
| highLimIn | input | 32 | Channel high limits, same packing |
| sysShutdown | output | 1 | Registered shutdown level |
| alert | output | 1 | Masked summary of the status registers |

## Verification
The bench builds the block with its default parameters: three external channels plus the internal one, with high-limit linking on channels 1 and 2. This configuration includes the gap at 1Ch between the external limits and the internal limit. It also lets a linked channel and an unlinked channel be set against each other under the same configuration value. A reset in the middle of the run shows that the lock is lifted, and a negative limit shows that the comparison is signed.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  localparam int MAX_CH = 4;
  localparam int IDX_W = $clog2(MAX_CH);
  localparam int CFG_MASK_BIT = 7;

  localparam logic [7:0] A_LIM_EXT0 = 8'h19;
  localparam logic [7:0] A_LIM_INT  = 8'h1D;
  localparam logic [7:0] A_CFG      = 8'h20;
  localparam logic [7:0] A_CRIT     = 8'h22;
  localparam logic [7:0] A_HIGH     = 8'h23;
  localparam logic [7:0] A_INT      = 8'h24;
  localparam logic [7:0] A_MASK     = 8'h25;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LIM, SEL_CFG, SEL_CRIT, SEL_HIGH, SEL_INT, SEL_MASK
  } rdSel_e;

  typedef struct packed {
    logic [MAX_CH-1:0] limWr;
    logic              cfgWr;
    logic              critClr;
    logic              highClr;
    logic              intClr;
    logic              maskWr;
    rdSel_e            rdSel;
    logic [IDX_W-1:0]  limIdx;
  } regStrobe_t;
endpackage

// File: rtl/tsm_ctrl.sv
module tsm_ctrl
  import tsm_pkg::*;
#(
  parameter int NUM_EXT = 3
) (
  input  logic [7:0] regAddr,
  input  logic       regWrEn,
  output regStrobe_t strb
);
  always_comb begin
    strb = '0;
    strb.rdSel = SEL_NONE;
    for (int i = 0; i < NUM_EXT; i++) begin
      if (regAddr == A_LIM_EXT0 + 8'(i)) begin
        strb.rdSel    = SEL_LIM;
        strb.limIdx   = IDX_W'(i);
        strb.limWr[i] = regWrEn;
      end
    end
    case (regAddr)
      A_LIM_INT: begin
        strb.rdSel          = SEL_LIM;
        strb.limIdx         = IDX_W'(NUM_EXT);
        strb.limWr[NUM_EXT] = regWrEn;
      end
      A_CFG:  begin strb.rdSel = SEL_CFG;  strb.cfgWr   = regWrEn; end
      A_CRIT: begin strb.rdSel = SEL_CRIT; strb.critClr = regWrEn; end
      A_HIGH: begin strb.rdSel = SEL_HIGH; strb.highClr = regWrEn; end
      A_INT:  begin strb.rdSel = SEL_INT;  strb.intClr  = regWrEn; end
      A_MASK: begin strb.rdSel = SEL_MASK; strb.maskWr  = regWrEn; end
      default: ;
    endcase
  end
endmodule

// File: rtl/tsm_datapath.sv
module tsm_datapath
  import tsm_pkg::*;
#(
  parameter int                NUM_CH       = 4,
  parameter int                DW           = 8,
  parameter logic [MAX_CH-1:0] HIGH_LINK_EN = 4'b0110,
  parameter logic [DW-1:0]     LIM_RST      = 8'h64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strb,
  input  logic [DW-1:0]        wrData,
  input  logic [NUM_CH*DW-1:0] tempIn,
  input  logic [NUM_CH*DW-1:0] highLimIn,
  output logic [DW-1:0]        rdData,
  output logic                 sysShutdown,
  output logic                 alert
);
  localparam logic [DW-1:0] CFG_KEEP =
    (DW'(1) << CFG_MASK_BIT) | (DW'(HIGH_LINK_EN) << 1);

  logic [NUM_CH-1:0][DW-1:0] limQ;
  logic [NUM_CH-1:0]         armedQ;
  logic [NUM_CH-1:0]         critHit, highHit, linkHit;
  logic [NUM_CH-1:0]         critStatQ, highStatQ;
  logic [1:0]                intStatQ;
  logic [2*NUM_CH-1:0]       maskQ;
  logic [DW-1:0]             cfgQ;
  logic                      sdQ;

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [DW-1:0] limR;
    logic          armR;
    logic [DW-1:0] tempG, highG;
    assign tempG = tempIn[g*DW +: DW];
    assign highG = highLimIn[g*DW +: DW];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        limR <= LIM_RST;
        armR <= 1'b0;
      end else if (strb.limWr[g] && !armR) begin
        limR <= wrData;
        armR <= 1'b1;
      end
    end
    assign limQ[g]   = limR;
    assign armedQ[g] = armR;

    assign critHit[g] = armR && ($signed(tempG) > $signed(limR));
    assign highHit[g] = $signed(tempG) >= $signed(highG);
    if (HIGH_LINK_EN[g]) begin : gLink
      assign linkHit[g] = highHit[g] && cfgQ[g+1];
    end else begin : gNoLink
      assign linkHit[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ      <= '0;
      maskQ     <= '0;
      critStatQ <= '0;
      highStatQ <= '0;
      intStatQ  <= '0;
      sdQ       <= 1'b0;
    end else begin
      if (strb.cfgWr)  cfgQ  <= wrData & CFG_KEEP;
      if (strb.maskWr) maskQ <= wrData[2*NUM_CH-1:0];
      critStatQ <= (critStatQ & ~(strb.critClr ? wrData[NUM_CH-1:0] : '0)) | critHit;
      highStatQ <= (highStatQ & ~(strb.highClr ? wrData[NUM_CH-1:0] : '0)) | highHit;
      intStatQ  <= (intStatQ & ~(strb.intClr ? wrData[1:0] : 2'b00))
                   | {|highHit, |critHit};
      sdQ       <= (|critHit) | (|linkHit);
    end
  end

  assign sysShutdown = sdQ;
  assign alert = !cfgQ[CFG_MASK_BIT] &&
                 (|((critStatQ & ~maskQ[NUM_CH-1:0]) |
                    (highStatQ & ~maskQ[2*NUM_CH-1:NUM_CH])));

  always_comb begin
    case (strb.rdSel)
      SEL_LIM:  rdData = limQ[strb.limIdx];
      SEL_CFG:  rdData = cfgQ;
      SEL_CRIT: rdData = DW'(critStatQ);
      SEL_HIGH: rdData = DW'(highStatQ);
      SEL_INT:  rdData = DW'(intStatQ);
      SEL_MASK: rdData = DW'(maskQ);
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/tsm_top.sv
module tsm_top
  import tsm_pkg::*;
#(
  parameter int                NUM_EXT      = 3,
  parameter int                DW           = 8,
  parameter logic [MAX_CH-1:0] HIGH_LINK_EN = 4'b0110
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [7:0]                  regAddr,
  input  logic                        regWrEn,
  input  logic [DW-1:0]               regWrData,
  output logic [DW-1:0]               regRdData,
  input  logic [(NUM_EXT+1)*DW-1:0]   tempIn,
  input  logic [(NUM_EXT+1)*DW-1:0]   highLimIn,
  output logic                        sysShutdown,
  output logic                        alert
);
  localparam int NUM_CH = NUM_EXT + 1;

  regStrobe_t strb;

  tsm_ctrl #(.NUM_EXT(NUM_EXT)) uCtrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strb   (strb)
  );

  tsm_datapath #(
    .NUM_CH(NUM_CH), .DW(DW), .HIGH_LINK_EN(HIGH_LINK_EN)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (regWrData),
    .tempIn     (tempIn),
    .highLimIn  (highLimIn),
    .rdData     (regRdData),
    .sysShutdown(sysShutdown),
    .alert      (alert)
  );
endmodule

// File: rtl/tsm_checker.sv
module tsm_checker #(
  parameter int          NUM_CH    = 4,
  parameter int          DW        = 8,
  parameter logic [DW-1:0] LINK_BITS = 8'h0C
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [7:0]                regAddr,
  input logic                      regWrEn,
  input logic [DW-1:0]             regWrData,
  input logic                      sysShutdown,
  input logic                      alert,
  input logic [NUM_CH-1:0]         armed,
  input logic [NUM_CH-1:0][DW-1:0] lims,
  input logic [DW-1:0]             cfg,
  input logic [NUM_CH-1:0]         critStat
);
  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      $past(armed[g]) |-> (armed[g] && $stable(lims[g]))); // R3
    AST_UNARMED_NO_CRIT: assert property (@(posedge clk) disable iff (!rstN)
      (!armed[g] && !critStat[g]) |=> !critStat[g]); // R4
    AST_CRIT_RISE_SHUTS: assert property (@(posedge clk) disable iff (!rstN)
      $rose(critStat[g]) |-> sysShutdown); // R5
  end

  AST_IDLE_NO_SHUTDOWN: assert property (@(posedge clk) disable iff (!rstN)
    (armed == '0 && (cfg & LINK_BITS) == '0) |=> !sysShutdown); // R7

  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 8'h20 && regWrData[7]) |=> !alert); // R10
endmodule

bind tsm_top tsm_checker #(
  .NUM_CH(NUM_CH), .DW(DW), .LINK_BITS(DW'(HIGH_LINK_EN) << 1)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .regAddr    (regAddr),
  .regWrEn    (regWrEn),
  .regWrData  (regWrData),
  .sysShutdown(sysShutdown),
  .alert      (alert),
  .armed      (uDp.armedQ),
  .lims       (uDp.limQ),
  .cfg        (uDp.cfgQ),
  .critStat   (uDp.critStatQ)
);

// File: tb/tsm_top_test.sv
`timescale 1ns/1ps
module tsm_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = 8'h00;
  logic [7:0]  regRdData;
  logic [7:0]  temp [4];
  logic [7:0]  hlim [4];
  logic [31:0] tempIn, highLimIn;
  logic        sysShutdown, alert;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  // reference model state
  logic [7:0] mLim [4];
  bit         mArm [4];
  logic [7:0] mCfg, mCrit, mHigh, mInt, mMask;
  bit         mSd;

  assign tempIn    = {temp[3], temp[2], temp[1], temp[0]};
  assign highLimIn = {hlim[3], hlim[2], hlim[1], hlim[0]};

  tsm_top uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .tempIn(tempIn),
    .highLimIn(highLimIn), .sysShutdown(sysShutdown), .alert(alert)
  );

  always #5 clk = ~clk;

  function automatic int chOf(logic [7:0] a);
    case (a)
      8'h19: return 0;
      8'h1A: return 1;
      8'h1B: return 2;
      8'h1D: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] mRead(logic [7:0] a);
    if (chOf(a) >= 0) return mLim[chOf(a)];
    case (a)
      8'h20: return mCfg;
      8'h22: return mCrit;
      8'h23: return mHigh;
      8'h24: return mInt;
      8'h25: return mMask;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit mAlert();
    return !mCfg[7] && (((mCrit & ~{4'h0, mMask[3:0]}) | (mHigh & ~{4'h0, mMask[7:4]})) != 8'h00);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin mLim[i] = 8'h64; mArm[i] = 0; end
      mCfg = 0; mCrit = 0; mHigh = 0; mInt = 0; mMask = 0; mSd = 0;
    end else begin
      logic [7:0] cHit, hHit;
      bit sd;
      int c;
      cHit = 0; hHit = 0; sd = 0;
      for (int i = 0; i < 4; i++) begin
        if (mArm[i] && $signed(temp[i]) > $signed(mLim[i])) begin cHit[i] = 1; sd = 1; end
        if ($signed(temp[i]) >= $signed(hlim[i])) begin
          hHit[i] = 1;
          if ((i == 1 && mCfg[2]) || (i == 2 && mCfg[3])) sd = 1;
        end
      end
      c = chOf(regAddr);
      if (regWrEn) begin
        if (c >= 0 && !mArm[c]) begin mLim[c] = regWrData; mArm[c] = 1; end
        if (regAddr == 8'h20) mCfg = regWrData & 8'h8C;
        if (regAddr == 8'h25) mMask = regWrData;
        if (regAddr == 8'h22) mCrit = mCrit & ~regWrData;
        if (regAddr == 8'h23) mHigh = mHigh & ~regWrData;
        if (regAddr == 8'h24) mInt = mInt & ~regWrData & 8'h03;
      end
      mCrit = mCrit | cHit;
      mHigh = mHigh | hHit;
      if (cHit != 0) mInt[0] = 1;
      if (hHit != 0) mInt[1] = 1;
      mSd = sd;
    end
  end

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h t=%0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R6 shutdown vs model", {7'd0, sysShutdown}, {7'd0, mSd});
      check("R10 alert vs model", {7'd0, alert}, {7'd0, mAlert()});
      check("R2 read vs model", regRdData, mRead(regAddr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #2;
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #2;
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(logic [7:0] a, logic [7:0] exp, string tag);
    @(posedge clk); #2;
    regAddr = a;
    @(negedge clk);
    check(tag, regRdData, exp);
  endtask

  task automatic pinChk(bit expSd, bit expAl, string tag);
    @(posedge clk); #2;
    @(negedge clk);
    check({tag, " shutdown"}, {7'd0, sysShutdown}, {7'd0, expSd});
    check({tag, " alert"}, {7'd0, alert}, {7'd0, expAl});
  endtask

  task automatic setT(int ch, logic [7:0] v);
    @(posedge clk); #2;
    temp[ch] = v;
  endtask

  task automatic pulseReset();
    @(posedge clk); #2; rstN = 1'b0;
    @(posedge clk); #2; rstN = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin temp[i] = 8'h00; hlim[i] = 8'h7F; end
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // R1 reset state
    rdChk(8'h19, 8'h64, "R1 lim0"); rdChk(8'h1A, 8'h64, "R1 lim1");
    rdChk(8'h1B, 8'h64, "R1 lim2"); rdChk(8'h1D, 8'h64, "R1 lim3");
    rdChk(8'h20, 8'h00, "R1 cfg");  rdChk(8'h22, 8'h00, "R1 crit");
    rdChk(8'h25, 8'h00, "R1 mask");
    pinChk(0, 0, "R1");
    // R2 unimplemented addresses
    rdChk(8'h1C, 8'h00, "R2 gap 1C"); rdChk(8'h21, 8'h00, "R2 gap 21");

    // R4 unarmed channel ignores overheat
    setT(0, 8'h70);
    rdChk(8'h22, 8'h00, "R4 crit status");
    pinChk(0, 0, "R4");

    // R3 first write arms, R5 hit
    wr(8'h19, 8'h50);
    rdChk(8'h19, 8'h50, "R3 first write");
    pinChk(1, 1, "R5");
    rdChk(8'h22, 8'h01, "R5 crit bit0");
    rdChk(8'h24, 8'h01, "R5 int bit0");
    wr(8'h19, 8'h20);
    rdChk(8'h19, 8'h50, "R3 second write ignored");

    // R5 equality, R6 release, R9 sticky and clear
    setT(0, 8'h50);
    pinChk(0, 1, "R6 equal no hit");
    rdChk(8'h22, 8'h01, "R9 sticky");
    wr(8'h22, 8'h01); rdChk(8'h22, 8'h00, "R9 clear crit");
    wr(8'h24, 8'h01); rdChk(8'h24, 8'h00, "R9 clear int");
    pinChk(0, 0, "R10 nothing pending");

    // R11 signed compare on internal channel
    wr(8'h1D, 8'hF6);
    setT(3, 8'h05);
    pinChk(1, 1, "R11 5 above -10");
    rdChk(8'h22, 8'h08, "R11 crit bit3");
    setT(3, 8'hF0);
    pinChk(0, 1, "R11 -16 below -10");
    wr(8'h22, 8'h08); wr(8'h24, 8'h01);

    // R8 high status, R7 linking
    hlim[1] = 8'h40;
    setT(1, 8'h40);
    rdChk(8'h23, 8'h02, "R8 high bit1");
    rdChk(8'h24, 8'h02, "R8 int bit1");
    pinChk(0, 1, "R7 unlinked");
    wr(8'h20, 8'h04);
    pinChk(1, 1, "R7 linked ch1");
    setT(1, 8'h3F);
    pinChk(0, 1, "R7 release");
    wr(8'h20, 8'hFF);
    rdChk(8'h20, 8'h8C, "R2 cfg kept bits");
    hlim[0] = 8'h10;
    pinChk(0, 0, "R7 ch0 never links, R10 global mask");
    rdChk(8'h23, 8'h03, "R8 ch0 high");

    // R10 per-bit mask
    wr(8'h20, 8'h00);
    wr(8'h25, 8'hF0);
    pinChk(0, 0, "R10 high masked");
    wr(8'h25, 8'h10);
    pinChk(0, 1, "R10 ch1 unmasked");

    // R9 set wins over clear
    wr(8'h23, 8'h01); rdChk(8'h23, 8'h03, "R9 set wins");
    wr(8'h23, 8'h02); rdChk(8'h23, 8'h01, "R9 clear bit1");

    // R3 lock released by reset
    pulseReset();
    rdChk(8'h19, 8'h64, "R3 after reset");
    wr(8'h19, 8'h33);
    rdChk(8'h19, 8'h33, "R3 rewrite after reset");
    repeat (4) @(posedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule